// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches the cycles of a processor bus and raises a break request when a cycle meets the conditions programmed into one of its two channels. Each channel compares the cycle address under a bit mask and, optionally, the address-space identifier. It also filters on the kind of cycle: instruction fetch or data access, read or write, and access size. The second channel can also compare the data word under its own mask. The data compare has an enable of its own.

A small word-addressed register interface programs the channels. Reads are combinational on the selected index. A matching data cycle produces a one-cycle break request in the cycle after the bus cycle. A matching fetch is held pending until an instruction boundary. The boundary is the next issue pulse when the break is taken before execution, or the next retire pulse when it is taken after execution. Each channel also sets a sticky match flag that software clears.

Top module: `bbk_top`

## Requirements
- R1: After reset the cycle-condition registers (index 4 for the first channel, 9 for the second) and the control register (index 12) read zero. A condition value of zero never matches, so no flag and no request appear.
- R2: When address enable (enable register bit 0) is set, an address bit takes part only if its bit in the address mask register is 0. A mismatch on any such bit blocks the match. With the enable clear, the address is ignored.
- R3: The identifier register is compared with `bus_asid` only when identifier enable (enable register bit 1) is set. Otherwise the identifier is ignored.
- R4: Condition bits [1:0] accept fetch cycles (bit 0) and data cycles (bit 1). Bits [3:2] accept reads (bit 2) and writes (bit 3). Fetch cycles count as reads.
- R5: Condition bits [5:4] filter on size: 0 accepts any size, and 1, 2 and 3 accept only `bus_size` 0 (byte), 1 (word) and 2 (long).
- R6: Only the second channel compares `bus_data`, and only when control bit 4 is set. A data bit whose data-mask bit is 1 is ignored. The first channel never looks at data.
- R7: A matching data cycle gives `brk_req` high for exactly the next cycle, with `brk_after` low.
- R8: With the channel's after bit clear (control bit 2 for the first channel, 3 for the second), a matching fetch raises `brk_req` in the cycle after the next `insn_issue` pulse. A retire pulse does not release it.
- R9: With the after bit set, a matching fetch raises `brk_req` with `brk_after` high in the cycle after the next `insn_retire` pulse. An issue pulse does not release it.
- R10: A match sets control bit 0 (first channel) or bit 1 (second channel), also seen on `brk_flag`. The flag stays set until software writes 0 to that bit. Writing 1 leaves it unchanged.
- R11: `brk_hit` shows which channels caused the request: bit 0 for the first channel and bit 1 for the second. Both bits are set when both channels match together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or manual) |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write | input | 1 | 1 for write |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_addr | input | 32 | Cycle address |
| bus_asid | input | 8 | Address-space identifier |
| bus_data | input | 32 | Cycle data |
| insn_issue | input | 1 | Instruction boundary before execution |
| insn_retire | input | 1 | Instruction boundary after execution |
| brk_req | output | 1 | Break request pulse |
| brk_after | output | 1 | Request is taken after execution |
| brk_hit | output | 2 | Channels causing the request |
| brk_flag | output | 2 | Sticky match flags |

## Verification
The bench sweeps every combination of kind, direction and size condition against every kind of bus cycle. A decoder that swaps the read and write bits, or treats a fetch as a data cycle, would set flags on the wrong cycles. The bench flips each of the 32 address bits under a mask. An inverted mask or a missing enable would match a masked-out address or miss a wanted one. It holds fetch breaks across the wrong kind of boundary to catch a design that releases on any pulse or fires at once. It also writes ones to set flags, to catch a flag that toggles or clears on any write.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
  typedef enum logic [3:0] {
    RG_ADDR_A = 4'd0, RG_AMSK_A = 4'd1, RG_ASID_A = 4'd2, RG_ENAB_A = 4'd3,
    RG_COND_A = 4'd4, RG_ADDR_B = 4'd5, RG_AMSK_B = 4'd6, RG_ASID_B = 4'd7,
    RG_ENAB_B = 4'd8, RG_COND_B = 4'd9, RG_DATA_B = 4'd10, RG_DMSK_B = 4'd11,
    RG_CTRL   = 4'd12
  } reg_idx_e;

  localparam int NUM_CH      = 2;
  localparam int CH_STRIDE   = 5;
  localparam int EN_ADDR     = 0;
  localparam int EN_ID       = 1;
  localparam int CTL_FLAG0   = 0;
  localparam int CTL_AFTER0  = 2;
  localparam int CTL_DATAEN  = 4;
  localparam int CTL_W       = 16;
  localparam int COND_W      = 16;
  localparam int ENAB_W      = 8;

  function automatic logic cycle_ok(input logic [COND_W-1:0] cond,
                                    input logic fetch, input logic write,
                                    input logic [1:0] size);
    logic kind_ok, dir_ok, size_ok;
    kind_ok = fetch ? cond[0] : cond[1];
    dir_ok  = (write && !fetch) ? cond[3] : cond[2];
    size_ok = (cond[5:4] == 2'd0) || (cond[5:4] == size + 2'd1);
    return kind_ok && dir_ok && size_ok;
  endfunction
endpackage

// File: rtl/bbk_regs.sv
module bbk_regs
  import bbk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [3:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NUM_CH-1:0]    hit_set,
  output logic [AW-1:0]        ch_addr  [NUM_CH],
  output logic [AW-1:0]        ch_amsk  [NUM_CH],
  output logic [IDW-1:0]       ch_asid  [NUM_CH],
  output logic [ENAB_W-1:0]    ch_enab  [NUM_CH],
  output logic [COND_W-1:0]    ch_cond  [NUM_CH],
  output logic [DW-1:0]        b_data,
  output logic [DW-1:0]        b_dmsk,
  output logic [NUM_CH-1:0]    ch_after,
  output logic                 data_en,
  output logic [NUM_CH-1:0]    flags
);
  logic ctl_wr;
  assign ctl_wr = cfg_wr_en && (cfg_addr == RG_CTRL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [3:0] BASE = 4'(c * CH_STRIDE);

    always_ff @(posedge clk) begin
      if (cfg_wr_en) begin
        if (cfg_addr == BASE + 4'd0) ch_addr[c] <= cfg_wdata[AW-1:0];
        if (cfg_addr == BASE + 4'd1) ch_amsk[c] <= cfg_wdata[AW-1:0];
        if (cfg_addr == BASE + 4'd2) ch_asid[c] <= cfg_wdata[IDW-1:0];
        if (cfg_addr == BASE + 4'd3) ch_enab[c] <= cfg_wdata[ENAB_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_cond[c]  <= '0;
        ch_after[c] <= 1'b0;
        flags[c]    <= 1'b0;
      end else begin
        if (cfg_wr_en && cfg_addr == BASE + 4'd4) ch_cond[c] <= cfg_wdata[COND_W-1:0];
        if (ctl_wr) ch_after[c] <= cfg_wdata[CTL_AFTER0 + c];
        if (hit_set[c])                           flags[c] <= 1'b1;
        else if (ctl_wr && !cfg_wdata[CTL_FLAG0 + c]) flags[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_wr_en && cfg_addr == RG_DATA_B) b_data <= cfg_wdata[DW-1:0];
    if (cfg_wr_en && cfg_addr == RG_DMSK_B) b_dmsk <= cfg_wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_en <= 1'b0;
    else if (ctl_wr) data_en <= cfg_wdata[CTL_DATAEN];
  end

  logic [CTL_W-1:0] ctl_view;
  always_comb begin
    ctl_view = '0;
    ctl_view[CTL_FLAG0 +: NUM_CH]  = flags;
    ctl_view[CTL_AFTER0 +: NUM_CH] = ch_after;
    ctl_view[CTL_DATAEN]           = data_en;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RG_ADDR_A: cfg_rdata[AW-1:0]     = ch_addr[0];
      RG_AMSK_A: cfg_rdata[AW-1:0]     = ch_amsk[0];
      RG_ASID_A: cfg_rdata[IDW-1:0]    = ch_asid[0];
      RG_ENAB_A: cfg_rdata[ENAB_W-1:0] = ch_enab[0];
      RG_COND_A: cfg_rdata[COND_W-1:0] = ch_cond[0];
      RG_ADDR_B: cfg_rdata[AW-1:0]     = ch_addr[1];
      RG_AMSK_B: cfg_rdata[AW-1:0]     = ch_amsk[1];
      RG_ASID_B: cfg_rdata[IDW-1:0]    = ch_asid[1];
      RG_ENAB_B: cfg_rdata[ENAB_W-1:0] = ch_enab[1];
      RG_COND_B: cfg_rdata[COND_W-1:0] = ch_cond[1];
      RG_DATA_B: cfg_rdata[DW-1:0]     = b_data;
      RG_DMSK_B: cfg_rdata[DW-1:0]     = b_dmsk;
      RG_CTRL:   cfg_rdata[CTL_W-1:0]  = ctl_view;
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bbk_chan.sv
module bbk_chan
  import bbk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int IDW      = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              bus_valid,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [AW-1:0]     bus_addr,
  input  logic [IDW-1:0]    bus_asid,
  input  logic [DW-1:0]     bus_data,
  input  logic [AW-1:0]     ref_addr,
  input  logic [AW-1:0]     ref_amsk,
  input  logic [IDW-1:0]    ref_asid,
  input  logic [ENAB_W-1:0] ref_enab,
  input  logic [COND_W-1:0] ref_cond,
  input  logic [DW-1:0]     ref_data,
  input  logic [DW-1:0]     ref_dmsk,
  input  logic              data_en,
  output logic              hit
);
  logic addr_ok, id_ok, kind_ok, data_ok;

  assign addr_ok = !ref_enab[EN_ADDR] || (((ref_addr ^ bus_addr) & ~ref_amsk) == '0);
  assign id_ok   = !ref_enab[EN_ID]   || (ref_asid == bus_asid);
  assign kind_ok = cycle_ok(ref_cond, bus_fetch, bus_write, bus_size);

  if (HAS_DATA) begin : g_data
    assign data_ok = !data_en || (((ref_data ^ bus_data) & ~ref_dmsk) == '0);
  end else begin : g_nodata
    logic unused_d;
    assign unused_d = ^{ref_data, ref_dmsk, data_en, bus_data};
    assign data_ok  = 1'b1;
  end

  assign hit = bus_valid && kind_ok && addr_ok && id_ok && data_ok;
endmodule

// File: rtl/bbk_seq.sv
module bbk_seq
  import bbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic              bus_fetch,
  input  logic [NUM_CH-1:0] ch_after,
  input  logic              insn_issue,
  input  logic              insn_retire,
  output logic              brk_req,
  output logic              brk_after,
  output logic [NUM_CH-1:0] brk_hit
);
  logic [NUM_CH-1:0] pend_q, pend_aft_q, fire, fire_aft;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    logic boundary;
    assign boundary    = pend_aft_q[c] ? insn_retire : insn_issue;
    assign fire[c]     = (hit[c] && !bus_fetch) || (pend_q[c] && boundary);
    assign fire_aft[c] = pend_q[c] && boundary && pend_aft_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c]     <= 1'b0;
        pend_aft_q[c] <= 1'b0;
      end else if (hit[c] && bus_fetch) begin
        pend_q[c]     <= 1'b1;
        pend_aft_q[c] <= ch_after[c];
      end else if (pend_q[c] && boundary) begin
        pend_q[c]     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req   <= 1'b0;
      brk_after <= 1'b0;
      brk_hit   <= '0;
    end else begin
      brk_req   <= |fire;
      brk_after <= |fire_aft;
      brk_hit   <= fire;
    end
  end
endmodule

// File: rtl/bbk_top.sv
module bbk_top
  import bbk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic [3:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           bus_valid,
  input  logic           bus_fetch,
  input  logic           bus_write,
  input  logic [1:0]     bus_size,
  input  logic [AW-1:0]  bus_addr,
  input  logic [IDW-1:0] bus_asid,
  input  logic [DW-1:0]  bus_data,
  input  logic           insn_issue,
  input  logic           insn_retire,
  output logic           brk_req,
  output logic           brk_after,
  output logic [1:0]     brk_hit,
  output logic [1:0]     brk_flag
);
  logic [AW-1:0]     ch_addr [NUM_CH];
  logic [AW-1:0]     ch_amsk [NUM_CH];
  logic [IDW-1:0]    ch_asid [NUM_CH];
  logic [ENAB_W-1:0] ch_enab [NUM_CH];
  logic [COND_W-1:0] ch_cond [NUM_CH];
  logic [DW-1:0]     b_data, b_dmsk;
  logic [NUM_CH-1:0] ch_after, hit;
  logic              data_en;

  bbk_regs #(.AW(AW), .DW(DW), .IDW(IDW)) u_regs (
    .clk, .rst_n, .cfg_wr_en, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .hit_set(hit), .ch_addr, .ch_amsk, .ch_asid, .ch_enab, .ch_cond,
    .b_data, .b_dmsk, .ch_after, .data_en, .flags(brk_flag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    bbk_chan #(.AW(AW), .DW(DW), .IDW(IDW), .HAS_DATA(c == NUM_CH - 1)) u_chan (
      .bus_valid, .bus_fetch, .bus_write, .bus_size, .bus_addr, .bus_asid, .bus_data,
      .ref_addr(ch_addr[c]), .ref_amsk(ch_amsk[c]), .ref_asid(ch_asid[c]),
      .ref_enab(ch_enab[c]), .ref_cond(ch_cond[c]),
      .ref_data(b_data), .ref_dmsk(b_dmsk), .data_en, .hit(hit[c])
    );
  end

  bbk_seq u_seq (
    .clk, .rst_n, .hit, .bus_fetch, .ch_after, .insn_issue, .insn_retire,
    .brk_req, .brk_after, .brk_hit
  );
endmodule

// File: rtl/bbk_chk.sv
module bbk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        bus_valid,
  input logic        bus_fetch,
  input logic        insn_issue,
  input logic        insn_retire,
  input logic        brk_req,
  input logic        brk_after,
  input logic [1:0]  brk_hit,
  input logic [1:0]  brk_flag
);
  AST_AFTER_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_after |-> $past(insn_retire) && brk_req); // R9
  AST_EARLY_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !brk_after && !$past(insn_issue) |-> $past(bus_valid && !bus_fetch)); // R7
  AST_HIT_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> brk_hit == 2'b00); // R11
  AST_FLAG_RISE_ON_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag[0]) || $rose(brk_flag[1]) |-> $past(bus_valid)); // R10
  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk_flag[0]) && !($past(cfg_wr_en) && $past(cfg_addr) == 4'd12 && !$past(cfg_wdata[0]))
    |-> brk_flag[0]); // R10
  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk_flag[1]) && !($past(cfg_wr_en) && $past(cfg_addr) == 4'd12 && !$past(cfg_wdata[1]))
    |-> brk_flag[1]); // R10
endmodule

bind bbk_top bbk_chk u_chk (.*);

// File: tb/sim_bbk_top.sv
module sim_bbk_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic bus_valid = 0, bus_fetch = 0, bus_write = 0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [7:0] bus_asid = '0;
  logic insn_issue = 0, insn_retire = 0;
  logic brk_req, brk_after;
  logic [1:0] brk_hit, brk_flag;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bbk_top u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic cyc(logic f, logic w, logic [1:0] s, logic [31:0] a, logic [7:0] id, logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_fetch = f; bus_write = w; bus_size = s;
    bus_addr = a; bus_asid = id; bus_data = d;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic pulse(logic iss, logic ret);
    @(negedge clk); insn_issue = iss; insn_retire = ret;
    @(negedge clk); insn_issue = 0; insn_retire = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(4'd4, v);  chk("R1 cond A", v, 0);
    rd(4'd9, v);  chk("R1 cond B", v, 0);
    rd(4'd12, v); chk("R1 ctrl", v, 0);
    wr(4'd0, 32'h1000); wr(4'd1, 0); wr(4'd2, 0); wr(4'd3, 0);
    wr(4'd5, 32'h1000); wr(4'd6, 0); wr(4'd7, 0); wr(4'd8, 0);
    wr(4'd10, 0); wr(4'd11, 0);
    cyc(0, 0, 2, 32'h1000, 0, 0);
    chk("R1 zero cond no req", brk_req, 0);
    rd(4'd12, v); chk("R1 zero cond no flag", v[1:0], 0);

    // R4 R5 R7 sweep on the first channel
    for (int k = 0; k < 4; k++)
      for (int dr = 0; dr < 4; dr++)
        for (int sz = 0; sz < 4; sz++)
          for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
              for (int bs = 0; bs < 3; bs++) begin
                logic ek, ed, es, em;
                if (f == 1 && w == 1) continue;
                ek = f ? k[0] : k[1];
                ed = w ? dr[1] : dr[0];
                es = (sz == 0) || (sz == bs + 1);
                em = ek && ed && es;
                wr(4'd4, 32'(k | (dr << 2) | (sz << 4)));
                cyc(f[0], w[0], bs[1:0], 32'h5555, 0, 0);
                if (f == 0) chk("R7 data req", {brk_req, brk_after}, {em, 1'b0});
                rd(4'd12, v); chk("R4 R5 flag", v[0], em);
                wr(4'd12, 0);
                if (f == 1) pulse(1, 0);
              end
    wr(4'd4, 0);

    // R2 masked address
    wr(4'd0, 32'h1234_5678); wr(4'd1, 32'h0000_00F0); wr(4'd3, 1); wr(4'd4, 32'h0F);
    cyc(0, 0, 2, 32'h1234_5678, 0, 0);
    chk("R2 exact", brk_req, 1);
    for (int i = 0; i < 32; i++) begin
      logic e;
      e = (i >= 4 && i < 8);
      cyc(0, 1, 0, 32'h1234_5678 ^ (32'd1 << i), 0, 0);
      chk("R2 bit flip", brk_req, e);
    end
    wr(4'd3, 0);
    cyc(0, 0, 1, 32'hDEAD_0000, 0, 0);
    chk("R2 address disabled", brk_req, 1);

    // R3 identifier
    wr(4'd2, 32'h5A); wr(4'd3, 2);
    cyc(0, 0, 1, 0, 8'h5A, 0); chk("R3 id match", brk_req, 1);
    cyc(0, 0, 1, 0, 8'h5B, 0); chk("R3 id mismatch", brk_req, 0);
    wr(4'd3, 0);
    cyc(0, 0, 1, 0, 8'h5B, 0); chk("R3 id disabled", brk_req, 1);
    wr(4'd12, 0);

    // R6 data compare on second channel
    wr(4'd4, 0);
    wr(4'd9, 32'h0F); wr(4'd10, 32'hCAFE_0000); wr(4'd11, 32'h0000_FFFF);
    wr(4'd12, 32'h10);
    cyc(0, 1, 2, 0, 0, 32'hCAFE_1234); chk("R6 masked data match", {brk_req, brk_hit}, 3'b110);
    cyc(0, 1, 2, 0, 0, 32'hCBFE_0000); chk("R6 data mismatch", brk_req, 0);
    wr(4'd12, 32'h00);
    cyc(0, 1, 2, 0, 0, 32'hCBFE_0000); chk("R6 data disabled", brk_req, 1);
    wr(4'd9, 0); wr(4'd4, 32'h0F); wr(4'd12, 32'h10);
    cyc(0, 1, 2, 0, 0, 32'h0BAD_0BAD); chk("R6 first channel ignores data", {brk_req, brk_hit}, 3'b101);

    // R11 both channels
    wr(4'd9, 32'h0F);
    cyc(0, 0, 2, 0, 0, 32'hCAFE_0000); chk("R11 both hit", {brk_req, brk_hit}, 3'b111);
    rd(4'd12, v); chk("R11 both flags", v[1:0], 2'b11);
    wr(4'd9, 0); wr(4'd12, 0);

    // R8 fetch before execution
    cyc(1, 0, 2, 0, 0, 0); chk("R8 no immediate req", brk_req, 0);
    @(negedge clk); chk("R8 held", brk_req, 0);
    pulse(0, 1); chk("R8 retire ignored", brk_req, 0);
    pulse(1, 0); chk("R8 release on issue", {brk_req, brk_after, brk_hit}, 4'b1001);
    @(negedge clk); chk("R8 single pulse", brk_req, 0);

    // R9 fetch after execution
    wr(4'd12, 32'h4);
    cyc(1, 0, 2, 0, 0, 0); chk("R9 no immediate req", brk_req, 0);
    pulse(1, 0); chk("R9 issue ignored", brk_req, 0);
    pulse(0, 1); chk("R9 release on retire", {brk_req, brk_after, brk_hit}, 4'b1101);

    // R10 sticky flags
    repeat (3) @(negedge clk);
    rd(4'd12, v); chk("R10 flag held", v[0], 1);
    wr(4'd12, 32'h5);
    rd(4'd12, v); chk("R10 write one keeps", v[0], 1);
    chk("R10 flag port", brk_flag, 2'b01);
    wr(4'd12, 32'h4);
    rd(4'd12, v); chk("R10 write zero clears", v[1:0], 2'b00);

    finish_run();
  end
endmodule